// File: doc/BRIEF.md
# Interline CCD Frame Sequencer

This block drives one complete frame of an interline CCD imager. After an accepted start request it moves every photodiode's charge into the vertical registers with a framed high-level pulse on the second vertical phase. It then steps the vertical registers once per row, or twice per row when vertical binning is on. For each row it hands a one-cycle line-start strobe to the horizontal line clock generator. The frame closes with a vertical retrace of a programmable number of idle line times and a one-cycle frame-done pulse.

The block can also place one substrate shutter pulse in a chosen row to set the exposure. That row's pulse sits after its vertical transfers and before its line-start strobe, followed by a quiet gap, so it never coincides with horizontal readout. Integration then runs from the end of that pulse to the next frame's photodiode read. The configuration inputs are captured when a frame is accepted. All durations are clock-cycle parameters. The default rows count includes the light-shielded and buffer rows that lead and trail every frame.

Top module: `ccd_frame_sequencer`

## Requirements
- R1: In reset and while idle, both vertical phase outputs show the hold state: phase 1 low (code 00), phase 2 mid (code 01). The line-start, shutter and frame-done outputs are 0.
- R2: Each accepted frame gives exactly one run of the high code (10) on phase 2, lasting T_V2H cycles. The run starts T_PED_OUT+T_PED_IN cycles after the first cycle of the frame and is followed by T_PED_OUT cycles before the first vertical transfer. The high code never appears on phase 1.
- R3: With binning off, a frame issues exactly ROWS line-start strobes, each one cycle wide, with one vertical transfer per row. A transfer is phase 1 at mid (01) for T_VSTEP cycles, then phase 2 at mid for T_VSTEP cycles.
- R4: With binning on, a frame issues ROWS/2 strobes and performs two vertical transfers ahead of each strobe.
- R5: frame_done rises exactly READ + lines*line_time + n*RETRACE_TICKS cycles after the frame's first cycle. READ is 2*T_PED_OUT+T_PED_IN+T_V2H. The line time is 2*T_VSTEP*(1 or 2)+T_HD+1+T_HREAD. A shuttered row adds T_SHUT+T_SHGAP. With n=0 the retrace is skipped.
- R6: During the retrace no strobe occurs and no vertical transfer occurs.
- R7: When the shutter is enabled and the shutter row is below the frame's row count, exactly one pulse of T_SHUT cycles occurs. It starts right after that row's last vertical transfer. At least T_SHGAP+1 cycles separate its end from that row's strobe. Otherwise no pulse occurs.
- R8: The shutter pulse never overlaps a line-start strobe or the T_HREAD cycles after one. It never overlaps the phase 2 high code.
- R9: frame_done is a one-cycle pulse, after which the block is idle. A start request during a frame is ignored and does not start a second frame.
- R10: The vertical phase outputs only ever carry codes 00, 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame start request, honoured only while idle |
| vbin_en | input | 1 | Vertical 2x binning for the frame |
| retrace_lines | input | NW | Retrace length n in line times |
| shutter_row | input | RW | Row index (0-based) that carries the shutter pulse |
| shutter_en | input | 1 | Enable the shutter pulse |
| v1_level | output | 2 | Vertical phase 1 level code (00 low, 01 mid, 10 high) |
| v2_level | output | 2 | Vertical phase 2 level code |
| line_start | output | 1 | One-cycle request to the line clock generator |
| shutter_pulse | output | 1 | Substrate shutter pulse |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every cycle, the assertions check the legal level codes and the exclusion of the shutter from the phase 2 high code. They also check that strobes and frame-done are single-cycle, that the retrace is quiet, that a shutter pulse is never directly followed by a strobe, and the exact width of the high run. Only the directed scenarios show the counting behaviour: the total frame length, the number of strobes and transfers in each binning mode, where the shutter lands, and its suppression when disabled or out of range. They also show that a start request inside a frame is dropped.

// File: rtl/ccd_fseq_pkg.sv
package ccd_fseq_pkg;

    typedef enum logic [1:0] {
        VLV_LOW  = 2'b00,
        VLV_MID  = 2'b01,
        VLV_HIGH = 2'b10
    } vlevel_e;

    typedef struct packed {
        vlevel_e ph1;
        vlevel_e ph2;
    } vclk_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_READ,
        FS_LINES,
        FS_RETRACE,
        FS_DONE
    } frame_state_e;

    function automatic vclk_t mk_vclk(input vlevel_e a, input vlevel_e b);
        vclk_t v;
        v.ph1 = a;
        v.ph2 = b;
        return v;
    endfunction

    function automatic vclk_t vclk_hold();
        return mk_vclk(VLV_LOW, VLV_MID);
    endfunction

    function automatic int unsigned line_cycles(input int unsigned vstep,
                                                input int unsigned passes,
                                                input int unsigned hd,
                                                input int unsigned hread);
        return 2 * vstep * passes + hd + 1 + hread;
    endfunction

endpackage

// File: rtl/ccd_pd_read.sv
module ccd_pd_read
    import ccd_fseq_pkg::*;
#(
    parameter int unsigned T_PED_OUT = 800,
    parameter int unsigned T_PED_IN  = 300,
    parameter int unsigned T_V2H     = 350,
    parameter int unsigned TW        = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    output logic  done,
    output vclk_t vclk
);
    typedef enum logic [2:0] {PR_IDLE, PR_LEAD, PR_INNER, PR_HIGH, PR_TRAIL} pr_state_e;

    localparam logic [TW-1:0] LEN_OUT  = TW'(T_PED_OUT - 1);
    localparam logic [TW-1:0] LEN_IN   = TW'(T_PED_IN - 1);
    localparam logic [TW-1:0] LEN_HIGH = TW'(T_V2H - 1);

    pr_state_e st;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PR_IDLE;
            cnt <= '0;
        end else if (st == PR_IDLE) begin
            if (go) begin
                st  <= PR_LEAD;
                cnt <= LEN_OUT;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end else begin
            unique case (st)
                PR_LEAD:  begin st <= PR_INNER; cnt <= LEN_IN;   end
                PR_INNER: begin st <= PR_HIGH;  cnt <= LEN_HIGH; end
                PR_HIGH:  begin st <= PR_TRAIL; cnt <= LEN_OUT;  end
                default:  begin st <= PR_IDLE;  cnt <= '0;       end
            endcase
        end
    end

    assign done = (st == PR_TRAIL) && (cnt == '0);

    always_comb begin
        unique case (st)
            PR_LEAD:  vclk = mk_vclk(VLV_MID, VLV_MID);
            PR_INNER: vclk = mk_vclk(VLV_LOW, VLV_MID);
            PR_HIGH:  vclk = mk_vclk(VLV_LOW, VLV_HIGH);
            PR_TRAIL: vclk = mk_vclk(VLV_LOW, VLV_MID);
            default:  vclk = vclk_hold();
        endcase
    end

    logic [TW-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)                        hi_run <= '0;
        else if (vclk.ph2 == VLV_HIGH)  hi_run <= hi_run + TW'(1);
        else                            hi_run <= '0;
    end

    AST_V2H_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (vclk.ph2 != VLV_HIGH && hi_run != '0) |-> hi_run == TW'(T_V2H)); // R2

endmodule

// File: rtl/ccd_line_eng.sv
module ccd_line_eng
    import ccd_fseq_pkg::*;
#(
    parameter int unsigned T_VSTEP = 20,
    parameter int unsigned T_HD    = 30,
    parameter int unsigned T_HREAD = 1060,
    parameter int unsigned T_SHUT  = 150,
    parameter int unsigned T_SHGAP = 20,
    parameter int unsigned TW      = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  logic  bin2,
    input  logic  shut,
    output logic  done,
    output logic  strobe,
    output logic  shutter,
    output vclk_t vclk
);
    typedef enum logic [2:0] {
        LE_IDLE, LE_XA, LE_XB, LE_SHUT, LE_GAP, LE_HD, LE_STRB, LE_HREAD
    } le_state_e;

    localparam logic [TW-1:0] LEN_STEP  = TW'(T_VSTEP - 1);
    localparam logic [TW-1:0] LEN_HD    = TW'(T_HD - 1);
    localparam logic [TW-1:0] LEN_HREAD = TW'(T_HREAD - 1);
    localparam logic [TW-1:0] LEN_SHUT  = TW'(T_SHUT - 1);
    localparam logic [TW-1:0] LEN_GAP   = TW'(T_SHGAP - 1);

    le_state_e st;
    logic [TW-1:0] cnt;
    logic pass, bin_q, shut_q;
    logic at_end;

    assign at_end = (cnt == '0);
    assign done   = (st == LE_HREAD) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LE_IDLE;
            cnt    <= '0;
            pass   <= 1'b0;
            bin_q  <= 1'b0;
            shut_q <= 1'b0;
        end else if (st == LE_IDLE || done) begin
            if (go) begin
                st     <= LE_XA;
                cnt    <= LEN_STEP;
                pass   <= 1'b0;
                bin_q  <= bin2;
                shut_q <= shut;
            end else begin
                st  <= LE_IDLE;
                cnt <= '0;
            end
        end else if (!at_end) begin
            cnt <= cnt - TW'(1);
        end else begin
            unique case (st)
                LE_XA: begin st <= LE_XB; cnt <= LEN_STEP; end
                LE_XB: begin
                    if (bin_q && !pass) begin
                        st   <= LE_XA;
                        cnt  <= LEN_STEP;
                        pass <= 1'b1;
                    end else if (shut_q) begin
                        st  <= LE_SHUT;
                        cnt <= LEN_SHUT;
                    end else begin
                        st  <= LE_HD;
                        cnt <= LEN_HD;
                    end
                end
                LE_SHUT: begin st <= LE_GAP;   cnt <= LEN_GAP;   end
                LE_GAP:  begin st <= LE_HD;    cnt <= LEN_HD;    end
                LE_HD:   begin st <= LE_STRB;  cnt <= '0;        end
                default: begin st <= LE_HREAD; cnt <= LEN_HREAD; end
            endcase
        end
    end

    assign strobe  = (st == LE_STRB);
    assign shutter = (st == LE_SHUT);

    always_comb begin
        unique case (st)
            LE_XA:   vclk = mk_vclk(VLV_MID, VLV_LOW);
            LE_XB:   vclk = mk_vclk(VLV_LOW, VLV_MID);
            default: vclk = vclk_hold();
        endcase
    end

    AST_SHUT_THEN_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        shutter |=> !strobe); // R7

endmodule

// File: rtl/ccd_retrace.sv
module ccd_retrace #(
    parameter int unsigned RL = 1111,
    parameter int unsigned NW = 8,
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [NW-1:0] n_lines,
    output logic          busy,
    output logic          done
);
    localparam logic [TW-1:0] LEN_LINE = TW'(RL - 1);

    logic [NW-1:0] left;
    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
            tick <= '0;
        end else if (!busy) begin
            if (go) begin
                busy <= 1'b1;
                left <= n_lines - NW'(1);
                tick <= LEN_LINE;
            end
        end else if (tick != '0) begin
            tick <= tick - TW'(1);
        end else if (left == '0) begin
            busy <= 1'b0;
        end else begin
            left <= left - NW'(1);
            tick <= LEN_LINE;
        end
    end

    assign done = busy && (tick == '0) && (left == '0);

endmodule

// File: rtl/ccd_frame_sequencer.sv
module ccd_frame_sequencer
    import ccd_fseq_pkg::*;
#(
    parameter int unsigned ROWS      = 1032,
    parameter int unsigned NW        = 8,
    parameter int unsigned TW        = 16,
    parameter int unsigned T_PED_OUT = 800,
    parameter int unsigned T_PED_IN  = 300,
    parameter int unsigned T_V2H     = 350,
    parameter int unsigned T_VSTEP   = 20,
    parameter int unsigned T_HD      = 30,
    parameter int unsigned T_HREAD   = 1060,
    parameter int unsigned T_SHUT    = 150,
    parameter int unsigned T_SHGAP   = 20,
    parameter int unsigned RETRACE_TICKS = line_cycles(T_VSTEP, 1, T_HD, T_HREAD),
    parameter int unsigned RW        = $clog2(ROWS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          vbin_en,
    input  logic [NW-1:0] retrace_lines,
    input  logic [RW-1:0] shutter_row,
    input  logic          shutter_en,
    output logic [1:0]    v1_level,
    output logic [1:0]    v2_level,
    output logic          line_start,
    output logic          shutter_pulse,
    output logic          frame_done
);
    localparam logic [RW-1:0] ROWS_FULL = RW'(ROWS);
    localparam logic [RW-1:0] ROWS_BIN  = RW'(ROWS / 2);

    frame_state_e st;
    logic          bin_q, shen_q;
    logic [NW-1:0] n_q;
    logic [RW-1:0] shrow_q;
    logic [RW-1:0] line_idx;
    logic [RW-1:0] last_idx;
    logic [RW-1:0] launch_idx;
    logic          last_line;

    logic  pd_go, pd_done;
    logic  ln_go, ln_done, ln_shut, ln_strobe, ln_shutter;
    logic  ret_go, ret_busy, ret_done;
    vclk_t pd_vclk, ln_vclk, vclk_o;

    assign last_idx   = (bin_q ? ROWS_BIN : ROWS_FULL) - RW'(1);
    assign last_line  = (line_idx == last_idx);
    assign launch_idx = (st == FS_READ) ? '0 : line_idx + RW'(1);

    assign pd_go  = (st == FS_IDLE) && frame_start;
    assign ln_go  = ((st == FS_READ) && pd_done) ||
                    ((st == FS_LINES) && ln_done && !last_line);
    assign ln_shut = shen_q && (launch_idx == shrow_q);
    assign ret_go = (st == FS_LINES) && ln_done && last_line && (n_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FS_IDLE;
            bin_q    <= 1'b0;
            shen_q   <= 1'b0;
            n_q      <= '0;
            shrow_q  <= '0;
            line_idx <= '0;
        end else begin
            unique case (st)
                FS_IDLE: if (frame_start) begin
                    st      <= FS_READ;
                    bin_q   <= vbin_en;
                    shen_q  <= shutter_en;
                    n_q     <= retrace_lines;
                    shrow_q <= shutter_row;
                end
                FS_READ: if (pd_done) begin
                    st       <= FS_LINES;
                    line_idx <= '0;
                end
                FS_LINES: if (ln_done) begin
                    if (!last_line)         line_idx <= line_idx + RW'(1);
                    else if (n_q != '0)     st <= FS_RETRACE;
                    else                    st <= FS_DONE;
                end
                FS_RETRACE: if (ret_done) st <= FS_DONE;
                default: st <= FS_IDLE;
            endcase
        end
    end

    ccd_pd_read #(
        .T_PED_OUT(T_PED_OUT), .T_PED_IN(T_PED_IN), .T_V2H(T_V2H), .TW(TW)
    ) u_pd (
        .clk(clk), .rst(rst), .go(pd_go), .done(pd_done), .vclk(pd_vclk)
    );

    ccd_line_eng #(
        .T_VSTEP(T_VSTEP), .T_HD(T_HD), .T_HREAD(T_HREAD),
        .T_SHUT(T_SHUT), .T_SHGAP(T_SHGAP), .TW(TW)
    ) u_line (
        .clk(clk), .rst(rst), .go(ln_go), .bin2(bin_q), .shut(ln_shut),
        .done(ln_done), .strobe(ln_strobe), .shutter(ln_shutter), .vclk(ln_vclk)
    );

    ccd_retrace #(
        .RL(RETRACE_TICKS), .NW(NW), .TW(TW)
    ) u_ret (
        .clk(clk), .rst(rst), .go(ret_go), .n_lines(n_q),
        .busy(ret_busy), .done(ret_done)
    );

    always_comb begin
        unique case (st)
            FS_READ:  vclk_o = pd_vclk;
            FS_LINES: vclk_o = ln_vclk;
            default:  vclk_o = vclk_hold();
        endcase
    end

    assign v1_level      = vclk_o.ph1;
    assign v2_level      = vclk_o.ph2;
    assign line_start    = ln_strobe;
    assign shutter_pulse = ln_shutter;
    assign frame_done    = (st == FS_DONE);

    AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (rst)
        v1_level != 2'b11 && v2_level != 2'b11 && v1_level != 2'b10); // R10
    AST_SHUT_NOT_HIGH: assert property (@(posedge clk) disable iff (rst)
        shutter_pulse |-> pd_vclk.ph2 != VLV_HIGH); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (!frame_done && !line_start)); // R9
    AST_RETRACE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ret_busy |-> (!line_start && ln_vclk.ph1 != VLV_MID)); // R6

endmodule

// File: tb/ccd_frame_sequencer_test.sv
module ccd_frame_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 8, NW = 4, TW = 8;
    localparam int PO = 4, PI = 2, VH = 3, VS = 2, HD = 2, HR = 6, SH = 3, SG = 2;
    localparam int RT = 13;
    localparam int RWB = $clog2(ROWS + 1);
    localparam int READ = 2 * PO + PI + VH;

    logic clk = 1'b0, rst = 1'b1;
    logic frame_start = 1'b0, vbin_en = 1'b0, shutter_en = 1'b0;
    logic [NW-1:0] retrace_lines = '0;
    logic [RWB-1:0] shutter_row = '0;
    logic [1:0] v1_level, v2_level;
    logic line_start, shutter_pulse, frame_done;

    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ccd_frame_sequencer #(
        .ROWS(ROWS), .NW(NW), .TW(TW), .T_PED_OUT(PO), .T_PED_IN(PI), .T_V2H(VH),
        .T_VSTEP(VS), .T_HD(HD), .T_HREAD(HR), .T_SHUT(SH), .T_SHGAP(SG),
        .RETRACE_TICKS(RT)
    ) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .vbin_en(vbin_en),
        .retrace_lines(retrace_lines), .shutter_row(shutter_row),
        .shutter_en(shutter_en), .v1_level(v1_level), .v2_level(v2_level),
        .line_start(line_start), .shutter_pulse(shutter_pulse),
        .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(v1_level == 2'b00 && v2_level == 2'b01, req, {v1_level, v2_level}, 1);
        chk(!line_start && !shutter_pulse && !frame_done, req,
            {line_start, shutter_pulse, frame_done}, 0);
    endtask

    // Runs one frame, measures it at the ports and compares with the requirements.
    task automatic run_frame(input bit bin, input int n, input bit shen, input int srow,
                             input bit poke_mid);
        int nl, passes, lt, extra, kexp, k;
        int strobes, xfers, hi_first, hi_total, hi_on_v1;
        int sh_cycles, sh_first, sh_last, sh_rises, overlap, last_strobe, late_xfer;
        int min_gap, read_left;
        bit shot, prev_sh;
        logic [1:0] prev_v1;
        nl = bin ? ROWS / 2 : ROWS;
        passes = bin ? 2 : 1;
        lt = 2 * VS * passes + HD + 1 + HR;
        shot = shen && (srow < nl);
        extra = shot ? SH + SG : 0;
        kexp = READ + nl * lt + n * RT + extra;
        strobes = 0; xfers = 0; hi_first = -1; hi_total = 0; hi_on_v1 = 0;
        sh_cycles = 0; sh_first = -1; sh_last = -1; sh_rises = 0; overlap = 0;
        last_strobe = -1; late_xfer = 0; min_gap = 1000; read_left = 0;
        prev_sh = 1'b0; prev_v1 = 2'b00;
        vbin_en = bin; retrace_lines = NW'(n); shutter_en = shen; shutter_row = RWB'(srow);
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        k = 0;
        forever begin
            if (poke_mid && k == 20) frame_start = 1'b1;
            if (poke_mid && k == 21) frame_start = 1'b0;
            if (v2_level == 2'b10) begin
                if (hi_first < 0) hi_first = k;
                hi_total++;
                if (shutter_pulse) overlap++;
            end
            if (v1_level == 2'b10) hi_on_v1++;
            if (v1_level == 2'b01 && prev_v1 != 2'b01 && k >= READ) begin
                xfers++;
                if (last_strobe >= 0 && strobes == nl) late_xfer++;
            end
            if (shutter_pulse) begin
                sh_cycles++;
                if (!prev_sh) begin sh_rises++; if (sh_first < 0) sh_first = k; end
                sh_last = k;
                if (line_start || read_left > 0) overlap++;
            end
            if (line_start) begin
                strobes++;
                last_strobe = k;
                read_left = HR;
                if (sh_last >= 0 && k - sh_last < min_gap) min_gap = k - sh_last;
            end else if (read_left > 0) read_left--;
            prev_sh = shutter_pulse;
            prev_v1 = v1_level;
            if (frame_done) break;
            if (k > 5000) begin
                chk(1'b0, "watchdog", k, kexp);
                break;
            end
            k++;
            @(negedge clk);
        end
        chk(k == kexp, "R5 frame length", k, kexp);
        chk(strobes == nl, bin ? "R4 strobe count" : "R3 strobe count", strobes, nl);
        chk(xfers == nl * passes, bin ? "R4 transfer count" : "R3 transfer count",
            xfers, nl * passes);
        chk(hi_first == PO + PI, "R2 high start", hi_first, PO + PI);
        chk(hi_total == VH && hi_on_v1 == 0, "R2 high width", hi_total, VH);
        chk(late_xfer == 0, "R6 retrace quiet", late_xfer, 0);
        chk(overlap == 0, "R8 shutter overlap", overlap, 0);
        if (shot) begin
            chk(sh_rises == 1 && sh_cycles == SH, "R7 shutter width", sh_cycles, SH);
            chk(sh_first == READ + srow * lt + 2 * VS * passes, "R7 shutter position",
                sh_first, READ + srow * lt + 2 * VS * passes);
            chk(min_gap >= SG + 1, "R7 shutter gap", min_gap, SG + HD + 1);
        end else begin
            chk(sh_cycles == 0, "R7 shutter suppressed", sh_cycles, 0);
        end
        @(negedge clk);
        check_idle("R9 idle after done");
    endtask

    task automatic test_reset();
        check_idle("R1 reset state");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 idle state");
    endtask

    task automatic test_mid_start();
        int extra_strobes = 0;
        run_frame(1'b0, 1, 1'b0, 0, 1'b1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (line_start || frame_done || v2_level == 2'b10) extra_strobes++;
        end
        chk(extra_strobes == 0, "R9 mid-frame start ignored", extra_strobes, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        run_frame(1'b0, 2, 1'b0, 0, 1'b0);
        run_frame(1'b1, 2, 1'b1, 1, 1'b0);
        run_frame(1'b0, 0, 1'b1, 5, 1'b0);
        run_frame(1'b0, 1, 1'b1, 7, 1'b0);
        run_frame(1'b0, 1, 1'b1, 8, 1'b0);
        run_frame(1'b1, 3, 1'b1, 5, 1'b0);
        run_frame(1'b1, 0, 1'b1, 0, 1'b0);
        test_mid_start();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule